// File: doc/BRIEF.md
# Segment Access Fault Classifier

This block judges a single memory operand reference, segment register load, selector verification or privileged instruction against segmentation and privilege rules and names the exception that applies, if one does. The surrounding pipeline presents the request on one cycle with a strobe. On the following clock edge the block produces a fault flag, an exception vector and a bus-lock indication, and holds them until the next strobe. A caller that only needs a verify result reads a zero-flag output, which reports a privilege mismatch without raising a fault.

Real mode treats every segment as 64 KiB. Protected mode uses the supplied limit, present bit and access-rights verdict, together with the privilege levels of the caller, the selector and the descriptor. Instructions for the system-management region are allowed only under a compound enable condition. When several problems are present at once, a fixed priority decides which vector is reported.

Top module: `segchk_top`

## Requirements
- R1: `faultValid`, `vecOut`, `lockOut` and `zeroFlag` are registered. They change only on the clock edge that samples `reqValid` high, and otherwise hold their values. Synchronous reset drives all four to 0. `vecOut` is 0 whenever `faultValid` is 0.
- R2: In real mode (`protMode`=0), a memory access (`reqKind`=0) whose last byte lies above offset FFFFh raises vector 12 when `segSel`=2 (stack segment) and vector 13 for any other `segSel`.
- R3: In protected mode, a memory access whose last byte lies above `segLimit`, or whose `rightsOk` is 0, raises vector 12 through the stack segment (`segSel`=2) and vector 13 through any other segment.
- R4: The last byte is `opAddr + opSize - 1`, computed one bit wider than the address. An `opSize` of 0 counts as one byte, and a carry past the top of the address space counts as a limit overrun.
- R5: In protected mode, a segment load (`reqKind`=1) with `descPresent`=0 raises vector 12 for the stack segment and vector 11 otherwise.
- R6: In protected mode, a segment load raises vector 13 when privilege does not match. For a non-stack target the rule is that max(`cpl`,`rpl`) must not exceed `dpl`. For the stack target, `cpl`, `rpl` and `dpl` must all be equal.
- R7: In protected mode, vector 13 is raised by `privInstr`=1 with `cpl`≠0, and by `ioSensitive`=1 with `cpl` > `iopl`.
- R8: `pmOnly`=1 in real mode raises vector 6.
- R9: `smmInstr`=1 raises vector 6 unless every one of these holds: `smiEnable`=1, `smmSize`≠0, `cpl`=0, and (`smmAccessCtl`=1 or `inSmiHandler`=1).
- R10: When several faults apply, the reported vector follows this order: vector 6 (R8, R9), then the privilege checks (R6, R7), then not-present (R5), then limit or rights (R2, R3).
- R11: `lockOut` is 1 for a request with `descTable`=1, and for any protected-mode segment load or verify (`reqKind`=2). Otherwise it is 0.
- R12: A verify request never faults because of a privilege mismatch. `zeroFlag` becomes 1 when max(`cpl`,`rpl`) ≤ `dpl` and 0 otherwise. Every other request kind leaves `zeroFlag` at 0. `reqKind`=3 performs only the instruction checks of R7 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe |
| protMode | input | 1 | 1 = protected mode, 0 = real mode |
| reqKind | input | 2 | 0 memory access, 1 segment load, 2 verify, 3 instruction only |
| segSel | input | 3 | Segment register; 2 = stack segment |
| opAddr | input | AW (32) | Operand start offset |
| opSize | input | SZW (4) | Operand size in bytes (0 treated as 1) |
| segLimit | input | AW (32) | Segment limit (protected mode) |
| descPresent | input | 1 | Descriptor present bit |
| rightsOk | input | 1 | Access-rights check passed |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requested privilege level of selector |
| dpl | input | 2 | Descriptor privilege level |
| iopl | input | 2 | I/O privilege level |
| privInstr | input | 1 | Instruction needs level 0 |
| ioSensitive | input | 1 | Instruction is I/O-privilege sensitive |
| pmOnly | input | 1 | Instruction valid only in protected mode |
| smmInstr | input | 1 | System-management instruction |
| smiEnable | input | 1 | System-management interrupt enabled |
| smmSize | input | SMMW (8) | System-management region size |
| smmAccessCtl | input | 1 | System-management access control bit |
| inSmiHandler | input | 1 | Executing inside the management handler |
| descTable | input | 1 | Request touches a descriptor table entry |
| faultValid | output | 1 | A fault applies |
| vecOut | output | 5 | Exception vector (0 when no fault) |
| lockOut | output | 1 | Assert bus lock for this request |
| zeroFlag | output | 1 | Verify result |

## Verification
The cases that are hardest to reach from the ports are coincident faults and operands that straddle a limit. Coincident faults test the priority order. Straddling operands include those whose last byte wraps past the top of the 32-bit space, where only the widened sum exposes the overrun. Random stimulus places the start offset within a few bytes of the segment limit, of FFFFh, or of the top of the address space. It also sets the rarer instruction flags with low probability so that they overlap with limit and load problems. Directed cases then pin each pairing of faults and each exact boundary byte.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  localparam int VEC_W = 5;

  typedef enum logic [1:0] {
    KIND_MEM    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_VERIFY = 2'd2,
    KIND_NONE   = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_UD   = 3'd1,
    FK_GP   = 3'd2,
    FK_NP   = 3'd3,
    FK_SS   = 3'd4
  } faultKind_e;

  localparam logic [VEC_W-1:0] VEC_UD = 5'd6;
  localparam logic [VEC_W-1:0] VEC_NP = 5'd11;
  localparam logic [VEC_W-1:0] VEC_SS = 5'd12;
  localparam logic [VEC_W-1:0] VEC_GP = 5'd13;
  localparam logic [2:0] SEG_STACK = 3'd2;

  // condition flags found by the datapath
  typedef struct packed {
    logic udHit;
    logic privHit;
    logic npHit;
    logic limHit;
    logic isStack;
    logic verifyOk;
    logic lockNeed;
  } cond_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    faultKind_e kind;
    logic       lock;
    logic       zf;
  } strobe_t;
endpackage

// File: rtl/segchk_dp.sv
module segchk_dp
  import segchk_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SZW  = 4,
  parameter int SMMW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                protMode,
  input  logic [1:0]          reqKind,
  input  logic [2:0]          segSel,
  input  logic [AW-1:0]       opAddr,
  input  logic [SZW-1:0]      opSize,
  input  logic [AW-1:0]       segLimit,
  input  logic                descPresent,
  input  logic                rightsOk,
  input  logic [1:0]          cpl,
  input  logic [1:0]          rpl,
  input  logic [1:0]          dpl,
  input  logic [1:0]          iopl,
  input  logic                privInstr,
  input  logic                ioSensitive,
  input  logic                pmOnly,
  input  logic                smmInstr,
  input  logic                smiEnable,
  input  logic [SMMW-1:0]     smmSize,
  input  logic                smmAccessCtl,
  input  logic                inSmiHandler,
  input  logic                descTable,
  output cond_t               cond,
  input  strobe_t             stb,
  output logic                faultValid,
  output logic [VEC_W-1:0]    vecOut,
  output logic                lockOut,
  output logic                zeroFlag
);
  localparam int EW = AW + 1;
  localparam logic [EW-1:0] REAL_LIM = EW'(17'h0FFFF);

  reqKind_e         kindIn;
  logic [SZW-1:0]   effSize;
  logic [EW-1:0]    endAddr;
  logic [EW-1:0]    activeLim;
  logic             overrun;
  logic             smmAllowed;
  logic [1:0]       maxLvl;
  logic             dataPrivBad;
  logic             stackPrivBad;
  logic             loadPrivBad;
  logic [VEC_W-1:0] vecNext;

  always_comb begin
    kindIn    = reqKind_e'(reqKind);
    effSize   = (opSize == '0) ? SZW'(1) : opSize;
    endAddr   = {1'b0, opAddr} + EW'(effSize) - EW'(1);
    activeLim = protMode ? {1'b0, segLimit} : REAL_LIM;
    overrun   = endAddr > activeLim;
  end

  always_comb begin
    smmAllowed   = smiEnable && (smmSize != '0) && (cpl == 2'd0)
                   && (smmAccessCtl || inSmiHandler);
    maxLvl       = (cpl > rpl) ? cpl : rpl;
    dataPrivBad  = maxLvl > dpl;
    stackPrivBad = (rpl != cpl) || (dpl != cpl);
    loadPrivBad  = (segSel == SEG_STACK) ? stackPrivBad : dataPrivBad;
  end

  always_comb begin
    cond.isStack  = (segSel == SEG_STACK);
    cond.udHit    = (pmOnly && !protMode) || (smmInstr && !smmAllowed);
    cond.privHit  = protMode && ((privInstr && cpl != 2'd0)
                    || (ioSensitive && cpl > iopl)
                    || (kindIn == KIND_LOAD && loadPrivBad));
    cond.npHit    = protMode && (kindIn == KIND_LOAD) && !descPresent;
    cond.limHit   = (kindIn == KIND_MEM) && (overrun || (protMode && !rightsOk));
    cond.verifyOk = !dataPrivBad;
    cond.lockNeed = descTable
                    || (protMode && (kindIn == KIND_LOAD || kindIn == KIND_VERIFY));
  end

  always_comb begin
    unique case (stb.kind)
      FK_UD:   vecNext = VEC_UD;
      FK_GP:   vecNext = VEC_GP;
      FK_NP:   vecNext = VEC_NP;
      FK_SS:   vecNext = VEC_SS;
      default: vecNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      faultValid <= 1'b0;
      vecOut     <= '0;
      lockOut    <= 1'b0;
      zeroFlag   <= 1'b0;
    end else if (stb.capture) begin
      faultValid <= (stb.kind != FK_NONE);
      vecOut     <= vecNext;
      lockOut    <= stb.lock;
      zeroFlag   <= stb.zf;
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !stb.capture |=> ($stable(faultValid) && $stable(vecOut)
                      && $stable(lockOut) && $stable(zeroFlag)));

  p_vec_legal_r10: assert property (@(posedge clk) disable iff (rst)
    faultValid ? (vecOut == VEC_UD || vecOut == VEC_NP || vecOut == VEC_SS
                  || vecOut == VEC_GP) : (vecOut == '0));

  p_ud_first_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && cond.udHit) |=> (faultValid && vecOut == VEC_UD));

  p_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && cond.lockNeed) |=> lockOut);

  p_np_stack_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.capture && cond.npHit && cond.isStack && !cond.udHit && !cond.privHit)
      |=> (vecOut == VEC_SS));
endmodule

// File: rtl/segchk_ctrl.sv
module segchk_ctrl
  import segchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  cond_t      cond,
  output strobe_t    stb
);
  faultKind_e pick;

  always_comb begin
    if (cond.udHit)        pick = FK_UD;
    else if (cond.privHit) pick = FK_GP;
    else if (cond.npHit)   pick = cond.isStack ? FK_SS : FK_NP;
    else if (cond.limHit)  pick = cond.isStack ? FK_SS : FK_GP;
    else                   pick = FK_NONE;
  end

  always_comb begin
    stb.capture = reqValid;
    stb.kind    = pick;
    stb.lock    = cond.lockNeed;
    stb.zf      = (reqKind == KIND_VERIFY) && cond.verifyOk;
  end

  p_verify_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqKind == KIND_VERIFY && !cond.udHit && !cond.privHit)
      |-> (stb.kind == FK_NONE));

  p_priv_over_np_r10: assert property (@(posedge clk) disable iff (rst)
    (reqValid && cond.privHit && !cond.udHit) |-> (stb.kind == FK_GP));
endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SZW  = 4,
  parameter int SMMW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic            protMode,
  input  logic [1:0]      reqKind,
  input  logic [2:0]      segSel,
  input  logic [AW-1:0]   opAddr,
  input  logic [SZW-1:0]  opSize,
  input  logic [AW-1:0]   segLimit,
  input  logic            descPresent,
  input  logic            rightsOk,
  input  logic [1:0]      cpl,
  input  logic [1:0]      rpl,
  input  logic [1:0]      dpl,
  input  logic [1:0]      iopl,
  input  logic            privInstr,
  input  logic            ioSensitive,
  input  logic            pmOnly,
  input  logic            smmInstr,
  input  logic            smiEnable,
  input  logic [SMMW-1:0] smmSize,
  input  logic            smmAccessCtl,
  input  logic            inSmiHandler,
  input  logic            descTable,
  output logic            faultValid,
  output logic [4:0]      vecOut,
  output logic            lockOut,
  output logic            zeroFlag
);
  cond_t   cond;
  strobe_t stb;

  segchk_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .cond     (cond),
    .stb      (stb)
  );

  segchk_dp #(.AW(AW), .SZW(SZW), .SMMW(SMMW)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .protMode     (protMode),
    .reqKind      (reqKind),
    .segSel       (segSel),
    .opAddr       (opAddr),
    .opSize       (opSize),
    .segLimit     (segLimit),
    .descPresent  (descPresent),
    .rightsOk     (rightsOk),
    .cpl          (cpl),
    .rpl          (rpl),
    .dpl          (dpl),
    .iopl         (iopl),
    .privInstr    (privInstr),
    .ioSensitive  (ioSensitive),
    .pmOnly       (pmOnly),
    .smmInstr     (smmInstr),
    .smiEnable    (smiEnable),
    .smmSize      (smmSize),
    .smmAccessCtl (smmAccessCtl),
    .inSmiHandler (inSmiHandler),
    .descTable    (descTable),
    .cond         (cond),
    .stb          (stb),
    .faultValid   (faultValid),
    .vecOut       (vecOut),
    .lockOut      (lockOut),
    .zeroFlag     (zeroFlag)
  );
endmodule

// File: tb/sim_segchk_top.sv
module sim_segchk_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        protMode;
  logic [1:0]  reqKind;
  logic [2:0]  segSel;
  logic [31:0] opAddr;
  logic [3:0]  opSize;
  logic [31:0] segLimit;
  logic        descPresent, rightsOk;
  logic [1:0]  cpl, rpl, dpl, iopl;
  logic        privInstr, ioSensitive, pmOnly, smmInstr, smiEnable;
  logic [7:0]  smmSize;
  logic        smmAccessCtl, inSmiHandler, descTable;
  logic        faultValid, lockOut, zeroFlag;
  logic [4:0]  vecOut;

  logic        expFv, expLock, expZf;
  logic [4:0]  expVec;
  string       expTag;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  segchk_top u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .protMode(protMode),
    .reqKind(reqKind), .segSel(segSel), .opAddr(opAddr), .opSize(opSize),
    .segLimit(segLimit), .descPresent(descPresent), .rightsOk(rightsOk),
    .cpl(cpl), .rpl(rpl), .dpl(dpl), .iopl(iopl), .privInstr(privInstr),
    .ioSensitive(ioSensitive), .pmOnly(pmOnly), .smmInstr(smmInstr),
    .smiEnable(smiEnable), .smmSize(smmSize), .smmAccessCtl(smmAccessCtl),
    .inSmiHandler(inSmiHandler), .descTable(descTable),
    .faultValid(faultValid), .vecOut(vecOut), .lockOut(lockOut),
    .zeroFlag(zeroFlag)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  // reference model built from the requirements
  function automatic void predict();
    logic [32:0] lastByte, lim;
    logic        stack, ud, pv, np, lm, smmOk, dataBad, stackBad;
    logic [1:0]  mx;
    lastByte = {1'b0, opAddr} + 33'((opSize == 4'd0) ? 4'd1 : opSize) - 33'd1;
    lim      = protMode ? {1'b0, segLimit} : 33'h0FFFF;
    stack    = (segSel == 3'd2);
    mx       = (cpl > rpl) ? cpl : rpl;
    dataBad  = mx > dpl;
    stackBad = !(cpl == rpl && rpl == dpl);
    smmOk    = smiEnable && smmSize != 8'd0 && cpl == 2'd0 && (smmAccessCtl || inSmiHandler);
    ud       = (pmOnly && !protMode) || (smmInstr && !smmOk);
    pv       = protMode && ((privInstr && cpl != 2'd0) || (ioSensitive && cpl > iopl)
               || (reqKind == 2'd1 && (stack ? stackBad : dataBad)));
    np       = protMode && reqKind == 2'd1 && !descPresent;
    lm       = reqKind == 2'd0 && (lastByte > lim || (protMode && !rightsOk));
    expFv = 1'b1;
    if (ud)      begin expVec = 5'd6;  expTag = (smmInstr && !smmOk) ? "R9" : "R8"; end
    else if (pv) begin expVec = 5'd13; expTag = (reqKind == 2'd1) ? "R6" : "R7"; end
    else if (np) begin expVec = stack ? 5'd12 : 5'd11; expTag = "R5"; end
    else if (lm) begin expVec = stack ? 5'd12 : 5'd13; expTag = protMode ? "R3" : "R2"; end
    else begin
      expFv = 1'b0; expVec = 5'd0;
      expTag = (reqKind == 2'd2) ? "R12" : (reqKind == 2'd0 ? "R4" : "R10");
    end
    expLock = descTable || (protMode && (reqKind == 2'd1 || reqKind == 2'd2));
    expZf   = (reqKind == 2'd2) && !dataBad;
  endfunction

  task automatic checkOut(string tag);
    checks++;
    if (faultValid !== expFv || vecOut !== expVec || lockOut !== expLock || zeroFlag !== expZf) begin
      errors++;
      $display("FAIL %s: actual fv=%0b vec=%0d lock=%0b zf=%0b expected fv=%0b vec=%0d lock=%0b zf=%0b",
               tag, faultValid, vecOut, lockOut, zeroFlag, expFv, expVec, expLock, expZf);
    end
  endtask

  task automatic issue(string tag);
    predict();
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkOut(tag == "" ? expTag : tag);
  endtask

  task automatic setBase();
    protMode = 1; reqKind = 2'd0; segSel = 3'd3; opAddr = 32'h100; opSize = 4'd4;
    segLimit = 32'hFFFF; descPresent = 1; rightsOk = 1;
    cpl = 0; rpl = 0; dpl = 0; iopl = 0;
    privInstr = 0; ioSensitive = 0; pmOnly = 0; smmInstr = 0;
    smiEnable = 1; smmSize = 8'h10; smmAccessCtl = 1; inSmiHandler = 0; descTable = 0;
  endtask

  task automatic randInputs();
    logic [2:0] mode;
    protMode = 1'($urandom); reqKind = 2'($urandom); segSel = 3'($urandom % 6);
    segLimit = $urandom; opSize = 4'($urandom % 9);
    mode = 3'($urandom % 4);
    case (mode)
      3'd0:    opAddr = segLimit - ($urandom % 6);
      3'd1:    opAddr = 32'hFFFF_FFFF - ($urandom % 6);
      3'd2:    opAddr = 32'h0000_FFFF - ($urandom % 6);
      default: opAddr = $urandom;
    endcase
    descPresent = ($urandom % 4) != 0; rightsOk = ($urandom % 4) != 0;
    cpl = 2'($urandom); rpl = 2'($urandom); dpl = 2'($urandom); iopl = 2'($urandom);
    privInstr = ($urandom % 6) == 0; ioSensitive = ($urandom % 6) == 0;
    pmOnly = ($urandom % 8) == 0; smmInstr = ($urandom % 6) == 0;
    smiEnable = ($urandom % 4) != 0; smmSize = ($urandom % 3 == 0) ? 8'd0 : 8'($urandom);
    smmAccessCtl = 1'($urandom); inSmiHandler = 1'($urandom); descTable = ($urandom % 4) == 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    setBase();
    repeat (3) @(negedge clk);
    expFv = 0; expVec = 0; expLock = 0; expZf = 0;
    checkOut("R1 reset");
    rst = 1'b0;
    @(negedge clk);

    setBase(); issue("R3 no fault");
    // hold: change inputs without strobe (R1)
    segLimit = 32'h0; issue("R3 limit"); segLimit = 32'hFFFF;
    randInputs(); @(negedge clk); checkOut("R1 hold");

    setBase(); protMode = 0; opAddr = 32'hFFFE; opSize = 2; issue("R2 exact fit");
    opSize = 3; issue("R2 ds overrun");
    segSel = 3'd2; opAddr = 32'hFFFF; opSize = 2; issue("R2 ss overrun");
    setBase(); segLimit = 32'hFFFF_FFFF; opAddr = 32'hFFFF_FFFE; opSize = 4; issue("R4 carry");
    opAddr = 32'hFFFF_FFFF; opSize = 0; issue("R4 size zero");
    setBase(); segSel = 3'd2; opAddr = 32'hFFFE; issue("R3 stack limit");
    setBase(); rightsOk = 0; issue("R3 rights");
    setBase(); reqKind = 2'd1; descPresent = 0; issue("R5 ds np");
    segSel = 3'd2; issue("R5 ss np");
    setBase(); reqKind = 2'd1; cpl = 3; rpl = 0; dpl = 2; issue("R6 data priv");
    segSel = 3'd2; cpl = 3; rpl = 3; dpl = 3; issue("R6 stack ok");
    dpl = 2; issue("R6 stack priv");
    setBase(); privInstr = 1; cpl = 1; issue("R7 priv instr");
    setBase(); ioSensitive = 1; cpl = 2; iopl = 1; issue("R7 io");
    iopl = 3; issue("R7 io ok");
    setBase(); protMode = 0; pmOnly = 1; issue("R8 real");
    protMode = 1; issue("R8 prot ok");
    setBase(); smmInstr = 1; issue("R9 allowed");
    smmAccessCtl = 0; inSmiHandler = 1; issue("R9 handler");
    inSmiHandler = 0; issue("R9 no ctl");
    smmAccessCtl = 1; smmSize = 0; issue("R9 size zero");
    smmSize = 8'h10; cpl = 1; issue("R9 cpl");
    setBase(); reqKind = 2'd1; descPresent = 0; cpl = 3; dpl = 0; issue("R10 priv over np");
    setBase(); protMode = 0; pmOnly = 1; segSel = 3'd2; opAddr = 32'hFFFF; issue("R10 ud over limit");
    setBase(); privInstr = 1; cpl = 2; dpl = 2; rpl = 2; segSel = 3'd2; segLimit = 0; issue("R10 priv over limit");
    setBase(); protMode = 0; descTable = 1; issue("R11 real desc");
    setBase(); reqKind = 2'd1; issue("R11 load");
    setBase(); issue("R11 mem no lock");
    setBase(); reqKind = 2'd2; cpl = 3; dpl = 0; issue("R12 verify bad");
    cpl = 0; dpl = 3; issue("R12 verify ok");

    for (int i = 0; i < 600; i++) begin
      randInputs();
      issue("");
      if (i % 5 == 0) begin
        randInputs();
        @(negedge clk);
        checkOut("R1 hold");
      end
    end

    summary();
    $finish;
  end
endmodule